// File: doc/BRIEF.md
# Serial Slave Hold Gate

This block is the pin-side front end of a serial memory slave. It brings chip select, the serial clock and an active-low hold request into the fast system clock domain. From these it decides, cycle by cycle, whether the command shifter may advance and whether the data-out line may be driven. The shifter gets a sample strobe for every rising serial clock edge and an update strobe for every falling edge. While a hold is in force, both strobes are withheld and the output drivers are switched off, so the bus can be shared without losing the state of a half-finished transfer.

A hold takes effect only while the slave is selected. The moment of entry and of exit depends on the level of the serial clock. When the clock is low, the change acts at once. When the clock is high, the change waits for the next falling clock edge. The hold function is dropped entirely when the quad-enable input is set, because that pin then carries data. Deselecting the slave clears any hold and sends a one-cycle clear strobe to the shifter's bit and byte counters. Clock polarity 0 and 1 (modes 0 and 3) are both accepted, with single-line or dual-line output.

Top module: `spi_hold_gate`

## Requirements
- R1: After reset, hold_o is 0, sample_en_o, update_en_o and cnt_clr_o are 0, and dout_oe_o is 2'b00.
- R2: While selected (cs_ni low) and not held, sample_en_o pulses for exactly one system cycle per rising sck_i edge, and update_en_o pulses for exactly one cycle per falling sck_i edge.
- R3: With quad_en_i=0, cs_ni low and sck_i low, a falling hold_ni sets hold_o within 4 system cycles.
- R4: If sck_i is high when hold_ni falls, hold_o stays 0 until the next falling sck_i edge. That edge still yields an update_en_o pulse, and hold_o rises after it.
- R5: If sck_i is low when hold_ni rises, hold_o returns to 0 within 4 system cycles.
- R6: If sck_i is high when hold_ni rises, hold_o stays 1 until the next falling sck_i edge. That edge yields no update_en_o pulse, and hold_o falls after it.
- R7: While hold_o is 1, sck_i edges produce no sample_en_o or update_en_o pulses, and dout_oe_o is 2'b00 even when drive_req_i is 1.
- R8: When quad_en_i is 1, hold_ni has no effect: hold_o stays 0 and the strobes continue.
- R9: With cs_ni high, hold is never entered. A rising cs_ni clears any hold and gives exactly one cnt_clr_o pulse of one cycle.
- R10: dout_oe_o[1] enables the single data-out line and is 1 when selected, not held and drive_req_i=1. dout_oe_o[0] enables the second line and is 1 only under the same terms with dual_i=1.
- R11: Mode 3 works like mode 0: sck_i idling high when cs_ni falls causes no spurious strobe, and a byte of 8 rising edges gives 8 sample pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than sck_i |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| hold_ni | input | 1 | Hold request pin, active low |
| quad_en_i | input | 1 | Quad mode on; hold function off |
| dual_i | input | 1 | Current transfer drives two output lines |
| drive_req_i | input | 1 | Shifter asks to drive data out |
| hold_o | output | 1 | Hold currently in force |
| sample_en_o | output | 1 | Shifter sample strobe (rising sck) |
| update_en_o | output | 1 | Shifter output-update strobe (falling sck) |
| cnt_clr_o | output | 1 | Clear strobe for shifter counters on deselect |
| dout_oe_o | output | 2 | Output enables: [1] data-out line, [0] second line |

## Verification
The assertions check properties that must hold on every cycle. Strobes and output enables are silent while the hold is in force. Sample and update strobes never coincide, and the clear strobe lasts one cycle and leaves the hold released. Quad mode keeps the hold off, and the second output enable never comes on without the first. Only the directed scenarios can show the timing that depends on the clock level. These include entry and exit deferred to a falling edge, whether that particular edge produces an update strobe, and exact pulse counts per byte in both clock polarities.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_ENTER_WAIT = 2'd1,
    ST_HELD      = 2'd2,
    ST_EXIT_WAIT = 2'd3
  } hold_state_e;

  localparam int unsigned PIN_CS   = 0;
  localparam int unsigned PIN_SCK  = 1;
  localparam int unsigned PIN_HOLD = 2;
  localparam int unsigned NUM_PINS = 3;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= RST_VAL;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic sck_lvl_i,
  input  logic sck_fall_i,
  input  logic hold_req_i,
  input  logic hold_allow_i,
  output logic hold_o
);
  hold_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!sel_i || !hold_allow_i) begin
      state_d = ST_RUN;
    end else begin
      unique case (state_q)
        ST_RUN:
          if (hold_req_i) state_d = sck_lvl_i ? ST_ENTER_WAIT : ST_HELD;
        ST_ENTER_WAIT:
          if (!hold_req_i)     state_d = ST_RUN;
          else if (sck_fall_i) state_d = ST_HELD;
        ST_HELD:
          if (!hold_req_i) state_d = sck_lvl_i ? ST_EXIT_WAIT : ST_RUN;
        ST_EXIT_WAIT:
          if (hold_req_i)      state_d = ST_HELD;
          else if (sck_fall_i) state_d = ST_RUN;
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  // exit-wait still counts as held: the deferring falling edge is swallowed
  assign hold_o = (state_q == ST_HELD) || (state_q == ST_EXIT_WAIT);
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import spi_hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OE_LINES    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                sck_i,
  input  logic                hold_ni,
  input  logic                quad_en_i,
  input  logic                dual_i,
  input  logic                drive_req_i,
  output logic                hold_o,
  output logic                sample_en_o,
  output logic                update_en_o,
  output logic                cnt_clr_o,
  output logic [OE_LINES-1:0] dout_oe_o
);
  localparam logic [NUM_PINS-1:0] PIN_RST = NUM_PINS'((1 << PIN_CS) | (1 << PIN_HOLD));

  logic [NUM_PINS-1:0] pins_raw, pins_s, pins_rise, pins_fall;
  logic sel, active, drive;

  assign pins_raw[PIN_CS]   = cs_ni;
  assign pins_raw[PIN_SCK]  = sck_i;
  assign pins_raw[PIN_HOLD] = hold_ni;

  spi_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  spi_edge_det #(.WIDTH(NUM_PINS), .RST_VAL(PIN_RST)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pins_s),
    .rise_o(pins_rise),
    .fall_o(pins_fall)
  );

  assign sel = ~pins_s[PIN_CS];

  spi_hold_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel),
    .sck_lvl_i   (pins_s[PIN_SCK]),
    .sck_fall_i  (pins_fall[PIN_SCK]),
    .hold_req_i  (~pins_s[PIN_HOLD]),
    .hold_allow_i(~quad_en_i),
    .hold_o      (hold_o)
  );

  assign active      = sel & ~hold_o;
  assign sample_en_o = active & pins_rise[PIN_SCK];
  assign update_en_o = active & pins_fall[PIN_SCK];
  assign cnt_clr_o   = pins_rise[PIN_CS];
  assign drive       = active & drive_req_i;

  // line OE_LINES-1 is the single data-out line; lower lines join in wide mode
  for (genvar l = 0; l < OE_LINES; l++) begin : g_oe
    if (l == OE_LINES - 1) begin : g_main
      assign dout_oe_o[l] = drive;
    end else begin : g_wide
      assign dout_oe_o[l] = drive & dual_i;
    end
  end
endmodule

// File: rtl/spi_hold_gate_chk.sv
module spi_hold_gate_chk #(
  parameter int unsigned OE_LINES = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                quad_en_i,
  input logic                hold_o,
  input logic                sample_en_o,
  input logic                update_en_o,
  input logic                cnt_clr_o,
  input logic [OE_LINES-1:0] dout_oe_o
);
  p_held_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (!sample_en_o && !update_en_o && dout_oe_o == '0));

  p_strobe_excl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_en_o && update_en_o));

  p_quad_no_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quad_en_i |=> !hold_o);

  p_clr_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_o |=> !cnt_clr_o);

  p_clr_releases_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_o |=> !hold_o);

  p_wide_needs_main_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_oe_o[0] |-> dout_oe_o[OE_LINES-1]);
endmodule

bind spi_hold_gate spi_hold_gate_chk #(.OE_LINES(OE_LINES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .quad_en_i  (quad_en_i),
  .hold_o     (hold_o),
  .sample_en_o(sample_en_o),
  .update_en_o(update_en_o),
  .cnt_clr_o  (cnt_clr_o),
  .dout_oe_o  (dout_oe_o)
);

// File: tb/spi_hold_gate_tb_top.sv
`timescale 1ns/1ps
module spi_hold_gate_tb_top;
  localparam real CLK_HALF = 2.5;
  localparam int  SETTLE   = 6;
  localparam int  WDOG     = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1;
  logic quad_en = 1'b0, dual = 1'b0, drive_req = 1'b0;
  logic hold, sample_en, update_en, cnt_clr;
  logic [1:0] dout_oe;

  int tests = 0, fails = 0;
  int smp_cnt = 0, upd_cnt = 0, clr_cnt = 0, cyc = 0;
  bit done = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  spi_hold_gate dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .hold_ni(hold_n),
    .quad_en_i(quad_en), .dual_i(dual), .drive_req_i(drive_req),
    .hold_o(hold), .sample_en_o(sample_en), .update_en_o(update_en),
    .cnt_clr_o(cnt_clr), .dout_oe_o(dout_oe)
  );

  always @(negedge clk) begin
    if (sample_en) smp_cnt++;
    if (update_en) upd_cnt++;
    if (cnt_clr)   clr_cnt++;
    cyc++;
    if (cyc > WDOG && !done) begin
      fails++; tests++;
      $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WDOG);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sck_set(input logic v);
    sck = v;
    wait_clk(SETTLE);
  endtask

  task automatic deselect();
    cs_n = 1'b1; hold_n = 1'b1; sck = 1'b0; drive_req = 1'b0; dual = 1'b0; quad_en = 1'b0;
    wait_clk(SETTLE);
  endtask

  task automatic t_reset();
    chk(hold == 0 && sample_en == 0 && update_en == 0 && cnt_clr == 0, "R1 strobes/hold", hold, 0);
    chk(dout_oe == 2'b00, "R1 oe", dout_oe, 0);
  endtask

  task automatic t_mode0_byte();
    int s0, u0;
    cs_n = 1'b0; wait_clk(SETTLE);
    s0 = smp_cnt; u0 = upd_cnt;
    for (int b = 0; b < 8; b++) begin sck_set(1'b1); sck_set(1'b0); end
    chk(smp_cnt - s0 == 8, "R2 sample count", smp_cnt - s0, 8);
    chk(upd_cnt - u0 == 8, "R2 update count", upd_cnt - u0, 8);
    deselect();
  endtask

  task automatic t_hold_low_clk();
    int s0;
    cs_n = 1'b0; drive_req = 1'b1; wait_clk(SETTLE);
    hold_n = 1'b0; wait_clk(4);
    chk(hold == 1, "R3 immediate entry", hold, 1);
    chk(dout_oe == 2'b00, "R7 oe off while held", dout_oe, 0);
    s0 = smp_cnt;
    for (int b = 0; b < 3; b++) begin sck_set(1'b1); sck_set(1'b0); end
    chk(smp_cnt == s0, "R7 clocks ignored", smp_cnt - s0, 0);
    hold_n = 1'b1; wait_clk(4);
    chk(hold == 0, "R5 immediate exit", hold, 0);
    chk(dout_oe == 2'b10, "R10 single oe", dout_oe, 2);
    deselect();
  endtask

  task automatic t_hold_high_clk();
    int u0;
    cs_n = 1'b0; wait_clk(SETTLE);
    sck_set(1'b1);
    hold_n = 1'b0; wait_clk(SETTLE);
    chk(hold == 0, "R4 entry deferred", hold, 0);
    u0 = upd_cnt;
    sck_set(1'b0);
    chk(upd_cnt - u0 == 1, "R4 deferring edge updates", upd_cnt - u0, 1);
    chk(hold == 1, "R4 entered after fall", hold, 1);
    sck_set(1'b1);
    hold_n = 1'b1; wait_clk(SETTLE);
    chk(hold == 1, "R6 exit deferred", hold, 1);
    u0 = upd_cnt;
    sck_set(1'b0);
    chk(upd_cnt == u0, "R6 deferring edge swallowed", upd_cnt - u0, 0);
    chk(hold == 0, "R6 exit after fall", hold, 0);
    deselect();
  endtask

  task automatic t_quad();
    int s0;
    quad_en = 1'b1; cs_n = 1'b0; wait_clk(SETTLE);
    hold_n = 1'b0; wait_clk(SETTLE);
    chk(hold == 0, "R8 hold ignored in quad", hold, 0);
    s0 = smp_cnt;
    sck_set(1'b1); sck_set(1'b0);
    chk(smp_cnt - s0 == 1, "R8 strobes continue", smp_cnt - s0, 1);
    deselect();
  endtask

  task automatic t_deselect();
    int c0;
    hold_n = 1'b0; wait_clk(SETTLE);
    chk(hold == 0, "R9 no hold while deselected", hold, 0);
    hold_n = 1'b1; cs_n = 1'b0; wait_clk(SETTLE);
    hold_n = 1'b0; wait_clk(SETTLE);
    chk(hold == 1, "R9 held before deselect", hold, 1);
    c0 = clr_cnt;
    cs_n = 1'b1; wait_clk(SETTLE);
    chk(hold == 0, "R9 deselect clears hold", hold, 0);
    chk(clr_cnt - c0 == 1, "R9 one clear pulse", clr_cnt - c0, 1);
    deselect();
  endtask

  task automatic t_dual_oe();
    cs_n = 1'b0; dual = 1'b1; drive_req = 1'b1; wait_clk(SETTLE);
    chk(dout_oe == 2'b11, "R10 dual oe", dout_oe, 3);
    drive_req = 1'b0; wait_clk(1);
    chk(dout_oe == 2'b00, "R10 no request no drive", dout_oe, 0);
    deselect();
  endtask

  task automatic t_mode3();
    int s0, u0;
    sck = 1'b1; wait_clk(SETTLE);
    s0 = smp_cnt; u0 = upd_cnt;
    cs_n = 1'b0; wait_clk(SETTLE);
    chk(smp_cnt == s0 && upd_cnt == u0, "R11 no strobe at select", smp_cnt - s0 + upd_cnt - u0, 0);
    for (int b = 0; b < 8; b++) begin sck_set(1'b0); sck_set(1'b1); end
    chk(smp_cnt - s0 == 8, "R11 mode3 samples", smp_cnt - s0, 8);
    chk(upd_cnt - u0 == 8, "R11 mode3 updates", upd_cnt - u0, 8);
    deselect();
  endtask

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1'b1;
    wait_clk(SETTLE);
    t_mode0_byte();
    t_hold_low_clk();
    t_hold_high_clk();
    t_quad();
    t_deselect();
    t_dual_oe();
    t_mode3();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule